// File: doc/BRIEF.md
# Integer Compare and Branch Target Unit

This block is the combinational compare and branch-target stage of an integer execution pipeline. It takes the opcode byte, the instruction's address, two register values with their register numbers, and the raw 16-bit and 32-bit offset fields of the instruction. From these it computes two things. For the two compare opcodes it produces a three-way ordering result as a 64-bit value. For the control-flow opcodes it decides whether the branch is taken and computes the next program counter.

A relative branch target is measured from the address of the first byte of the offset field. It is not measured from the start of the instruction or from the following one. A jump whose offset follows the opcode directly therefore uses the instruction address plus one as its base. A two-register conditional branch uses the instruction address plus three. All address arithmetic wraps modulo 2^64.

The decode, the operand muxing and the target adder all sit in one module with no clock. The surrounding pipeline registers its outputs.

Top module: `cmp_branch_unit`

## Requirements
- R1: Opcode 0x1E compares the two operands as unsigned 64-bit numbers and drives `cmp_result` to all ones (-1) when A<B, 0 when A==B and 1 when A>B, with `cmp_valid` high.
- R2: Opcode 0x1F does the same compare with both operands taken as signed two's-complement 64-bit numbers.
- R3: An operand whose register number is 0 is taken as zero, whatever value is presented on its value port.
- R4: The conditional branch opcodes evaluate A against B as follows: 0x56 taken when equal, 0x57 when not equal, 0x58 when A<B unsigned, 0x59 when A>B unsigned, 0x5A when A<B signed, 0x5B when A>B signed.
- R5: A taken conditional branch sets `next_pc` to the instruction address plus 3 plus the sign-extended 16-bit offset.
- R6: A conditional branch that is not taken sets `next_pc` to the instruction address plus 5, with `taken` low and `is_flow` high.
- R7: Opcode 0x53 is always taken and sets `next_pc` to the instruction address plus 1 plus the sign-extended 32-bit offset.
- R8: Opcode 0x77 is always taken and sets `next_pc` to the instruction address plus 1 plus the sign-extended 16-bit offset.
- R9: Target arithmetic wraps modulo 2^64 in both directions.
- R10: Any other opcode drives `taken`, `is_flow` and `cmp_valid` low, `cmp_result` to zero and `next_pc` equal to the instruction address. A compare opcode is not a control-flow opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 8 | Opcode byte of the current instruction |
| pc | input | 64 | Address of the opcode byte |
| a_sel | input | 8 | Register number of operand A |
| a_val | input | 64 | Register value read for operand A |
| b_sel | input | 8 | Register number of operand B |
| b_val | input | 64 | Register value read for operand B |
| off16 | input | 16 | 16-bit relative offset field |
| off32 | input | 32 | 32-bit relative offset field |
| cmp_valid | output | 1 | High for the two compare opcodes |
| cmp_result | output | 64 | Three-way ordering result: -1, 0 or 1 |
| is_flow | output | 1 | High for jump and conditional branch opcodes |
| taken | output | 1 | Branch or jump is taken |
| next_pc | output | 64 | Address of the next instruction to fetch |

## Verification
The embedded checks are immediate assertions evaluated whenever the inputs move. They assume that every input carries a known value and that the opcode and operands settle together, so that no check sees a half-updated decode. The stimulus tasks therefore drive every input at once, never leave one undriven, and wait a fixed delay before sampling the outputs. Offsets are chosen at the sign boundaries, and the addresses near zero and near the top of the space, so that the target adder really wraps.

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit #(
  parameter int XLEN = 64,
  parameter int SEL_W = 8,
  parameter int SHORT_W = 16,
  parameter int LONG_W = 32
) (
  input  logic [7:0]         op,
  input  logic [XLEN-1:0]    pc,
  input  logic [SEL_W-1:0]   a_sel,
  input  logic [XLEN-1:0]    a_val,
  input  logic [SEL_W-1:0]   b_sel,
  input  logic [XLEN-1:0]    b_val,
  input  logic [SHORT_W-1:0] off16,
  input  logic [LONG_W-1:0]  off32,
  output logic               cmp_valid,
  output logic [XLEN-1:0]    cmp_result,
  output logic               is_flow,
  output logic               taken,
  output logic [XLEN-1:0]    next_pc
);
  localparam logic [7:0] OP_CMPU  = 8'h1E;
  localparam logic [7:0] OP_CMPS  = 8'h1F;
  localparam logic [7:0] OP_JMP   = 8'h53;
  localparam logic [7:0] OP_BEQ   = 8'h56;
  localparam logic [7:0] OP_BNE   = 8'h57;
  localparam logic [7:0] OP_BLTU  = 8'h58;
  localparam logic [7:0] OP_BGTU  = 8'h59;
  localparam logic [7:0] OP_BLTS  = 8'h5A;
  localparam logic [7:0] OP_BGTS  = 8'h5B;
  localparam logic [7:0] OP_JMP16 = 8'h77;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] BASE_SHORT_JMP = XLEN'(1);
  localparam logic [XLEN-1:0] BASE_COND = XLEN'(3);
  localparam logic [XLEN-1:0] COND_LEN = XLEN'(5);

  logic [XLEN-1:0] a_eff, b_eff;
  logic            eq, lt_u, lt_s, gt_u, gt_s;
  logic            is_cmp, is_cond, is_jmp32, is_jmp16;
  logic            cond_hit;
  logic [XLEN-1:0] off_ext, base_add, target;

  assign a_eff = (a_sel == '0) ? '0 : a_val;
  assign b_eff = (b_sel == '0) ? '0 : b_val;

  assign eq   = (a_eff == b_eff);
  assign lt_u = (a_eff < b_eff);
  assign lt_s = ($signed(a_eff) < $signed(b_eff));
  assign gt_u = !lt_u && !eq;
  assign gt_s = !lt_s && !eq;

  assign is_cmp   = (op == OP_CMPU) || (op == OP_CMPS);
  assign is_cond  = (op >= OP_BEQ) && (op <= OP_BGTS);
  assign is_jmp32 = (op == OP_JMP);
  assign is_jmp16 = (op == OP_JMP16);

  always_comb begin
    unique case (op)
      OP_BEQ:  cond_hit = eq;
      OP_BNE:  cond_hit = !eq;
      OP_BLTU: cond_hit = lt_u;
      OP_BGTU: cond_hit = gt_u;
      OP_BLTS: cond_hit = lt_s;
      OP_BGTS: cond_hit = gt_s;
      default: cond_hit = 1'b0;
    endcase
  end

  always_comb begin
    cmp_result = '0;
    if (op == OP_CMPU)
      cmp_result = lt_u ? '1 : (eq ? '0 : ONE);
    else if (op == OP_CMPS)
      cmp_result = lt_s ? '1 : (eq ? '0 : ONE);
  end

  assign cmp_valid = is_cmp;

  assign off_ext  = is_jmp32 ? XLEN'($signed(off32)) : XLEN'($signed(off16));
  assign base_add = is_cond ? BASE_COND : BASE_SHORT_JMP;
  assign target   = pc + base_add + off_ext;

  assign is_flow = is_cond || is_jmp32 || is_jmp16;
  assign taken   = is_jmp32 || is_jmp16 || cond_hit;

  always_comb begin
    if (taken)        next_pc = target;
    else if (is_cond) next_pc = pc + COND_LEN;
    else              next_pc = pc;
  end

  always_comb begin
    p_taken_in_flow_r10: assert (!taken || is_flow)
      else $error("taken outside control-flow opcode");
    p_cmp_not_flow_r10: assert (!(cmp_valid && is_flow))
      else $error("compare flagged as control flow");
    p_cmp_range_r1: assert (!cmp_valid || cmp_result == '0 || cmp_result == ONE || cmp_result == '1)
      else $error("compare result out of range");
    p_cmp_idle_r2: assert (cmp_valid || cmp_result == '0)
      else $error("compare result nonzero without compare");
    p_uncond_taken_r7: assert (!(op == OP_JMP || op == OP_JMP16) || taken)
      else $error("unconditional jump not taken");
    p_fall_through_r6: assert (!(is_flow && !taken) || next_pc == pc + COND_LEN)
      else $error("fall-through address wrong");
    p_hold_pc_r10: assert (is_flow || next_pc == pc)
      else $error("next pc moved on non-flow opcode");
    p_zero_reg_r3: assert (!(a_sel == '0 && b_sel == '0 && op == OP_BEQ) || taken)
      else $error("zero register not read as zero");
  end
endmodule

// File: tb/test_cmp_branch_unit.sv
module test_cmp_branch_unit;
  logic        clk = 1'b0;
  logic [7:0]  op;
  logic [63:0] pc, a_val, b_val;
  logic [7:0]  a_sel, b_sel;
  logic [15:0] off16;
  logic [31:0] off32;
  logic        cmp_valid, is_flow, taken;
  logic [63:0] cmp_result, next_pc;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;

  always #2 clk = ~clk;

  cmp_branch_unit i_cmp_branch_unit (
    .op(op), .pc(pc), .a_sel(a_sel), .a_val(a_val), .b_sel(b_sel), .b_val(b_val),
    .off16(off16), .off32(off32), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
    .is_flow(is_flow), .taken(taken), .next_pc(next_pc)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o, input logic [63:0] p,
                       input logic [7:0] sa, input logic [63:0] va,
                       input logic [7:0] sb, input logic [63:0] vb,
                       input logic [15:0] s16, input logic [31:0] s32);
    op = o; pc = p; a_sel = sa; a_val = va; b_sel = sb; b_val = vb;
    off16 = s16; off32 = s32;
    @(negedge clk);
  endtask

  task automatic t_idle;
    drive(8'h02, 64'h1000, 8'd4, 64'd9, 8'd5, 64'd9, 16'h0010, 32'h10);
    chk("R10", "idle taken", {63'd0, taken}, 64'd0);
    chk("R10", "idle flow", {63'd0, is_flow}, 64'd0);
    chk("R10", "idle cmp_valid", {63'd0, cmp_valid}, 64'd0);
    chk("R10", "idle next_pc", next_pc, 64'h1000);
    chk("R10", "idle cmp_result", cmp_result, 64'd0);
    drive(8'h1D, 64'h2222, 8'd4, 64'd1, 8'd5, 64'd2, 16'h0010, 32'h10);
    chk("R10", "neighbour op next_pc", next_pc, 64'h2222);
    chk("R10", "neighbour op taken", {63'd0, taken}, 64'd0);
    drive(8'h1E, 64'h3000, 8'd4, 64'd1, 8'd5, 64'd2, 16'h0010, 32'h10);
    chk("R10", "compare not flow", {63'd0, is_flow}, 64'd0);
    chk("R10", "compare keeps pc", next_pc, 64'h3000);
  endtask

  task automatic t_cmpu;
    drive(8'h1E, 0, 8'd1, 64'd5, 8'd2, 64'd9, 0, 0);
    chk("R1", "unsigned less", cmp_result, M1);
    chk("R1", "cmp_valid", {63'd0, cmp_valid}, 64'd1);
    drive(8'h1E, 0, 8'd1, 64'd9, 8'd2, 64'd5, 0, 0);
    chk("R1", "unsigned greater", cmp_result, 64'd1);
    drive(8'h1E, 0, 8'd1, 64'd77, 8'd2, 64'd77, 0, 0);
    chk("R1", "unsigned equal", cmp_result, 64'd0);
    drive(8'h1E, 0, 8'd1, M1, 8'd2, 64'd1, 0, 0);
    chk("R1", "unsigned top value", cmp_result, 64'd1);
  endtask

  task automatic t_cmps;
    drive(8'h1F, 0, 8'd1, M1, 8'd2, 64'd1, 0, 0);
    chk("R2", "signed -1 vs 1", cmp_result, M1);
    drive(8'h1F, 0, 8'd1, 64'd1, 8'd2, M1, 0, 0);
    chk("R2", "signed 1 vs -1", cmp_result, 64'd1);
    drive(8'h1F, 0, 8'd1, 64'h8000_0000_0000_0000, 8'd2, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0);
    chk("R2", "signed min vs max", cmp_result, M1);
  endtask

  task automatic t_zero_reg;
    drive(8'h1E, 0, 8'd0, 64'd7, 8'd3, 64'd0, 0, 0);
    chk("R3", "reg0 compares as zero", cmp_result, 64'd0);
    drive(8'h56, 64'h4000, 8'd0, 64'd55, 8'd3, 64'd0, 16'h0004, 0);
    chk("R3", "reg0 equal branch taken", {63'd0, taken}, 64'd1);
    chk("R3", "reg0 equal branch target", next_pc, 64'h4007);
    drive(8'h1F, 0, 8'd6, M1, 8'd0, 64'd99, 0, 0);
    chk("R3", "reg0 as B operand", cmp_result, M1);
  endtask

  task automatic t_cond;
    drive(8'h56, 64'h2000, 8'd1, 64'd8, 8'd2, 64'd8, 16'h0010, 32'hDEAD);
    chk("R5", "beq taken target", next_pc, 64'h2013);
    chk("R4", "beq taken", {63'd0, taken}, 64'd1);
    drive(8'h57, 64'h2000, 8'd1, 64'd8, 8'd2, 64'd8, 16'h0010, 0);
    chk("R6", "bne fall through", next_pc, 64'h2005);
    chk("R6", "bne flow flag", {63'd0, is_flow}, 64'd1);
    chk("R4", "bne not taken", {63'd0, taken}, 64'd0);
    drive(8'h58, 64'h2000, 8'd1, 64'd1, 8'd2, M1, 16'h0010, 0);
    chk("R4", "bltu taken", {63'd0, taken}, 64'd1);
    drive(8'h59, 64'h2000, 8'd1, 64'd1, 8'd2, M1, 16'h0010, 0);
    chk("R4", "bgtu not taken", {63'd0, taken}, 64'd0);
    drive(8'h5A, 64'h2000, 8'd1, 64'd1, 8'd2, M1, 16'h0010, 0);
    chk("R4", "blts not taken", {63'd0, taken}, 64'd0);
    drive(8'h5B, 64'h2000, 8'd1, 64'd1, 8'd2, M1, 16'h0010, 0);
    chk("R4", "bgts taken", {63'd0, taken}, 64'd1);
    drive(8'h5B, 64'h2000, 8'd1, 64'd1, 8'd2, M1, 16'hFFF0, 0);
    chk("R5", "negative offset target", next_pc, 64'h1FF3);
    drive(8'h5A, 64'h2000, 8'd1, 64'd3, 8'd2, 64'd3, 16'h0010, 0);
    chk("R4", "blts equal not taken", {63'd0, taken}, 64'd0);
  endtask

  task automatic t_jmp32;
    drive(8'h53, 64'h100, 8'd1, 64'd1, 8'd2, 64'd2, 16'h7777, 32'h0000_0010);
    chk("R7", "jmp forward", next_pc, 64'h111);
    chk("R7", "jmp taken", {63'd0, taken}, 64'd1);
    drive(8'h53, 64'h100, 8'd1, 64'd1, 8'd2, 64'd2, 16'h0000, 32'h8000_0000);
    chk("R7", "jmp most negative", next_pc, 64'hFFFF_FFFF_8000_0101);
  endtask

  task automatic t_jmp16;
    drive(8'h77, 64'h100, 8'd1, 64'd1, 8'd2, 64'd2, 16'h0020, 32'h1234_5678);
    chk("R8", "short jmp forward", next_pc, 64'h121);
    drive(8'h77, 64'h100, 8'd1, 64'd1, 8'd2, 64'd2, 16'h8000, 32'h0);
    chk("R8", "short jmp most negative", next_pc, 64'hFFFF_FFFF_FFFF_8101);
    chk("R8", "short jmp taken", {63'd0, taken}, 64'd1);
  endtask

  task automatic t_wrap;
    drive(8'h53, 64'hFFFF_FFFF_FFFF_FFFE, 8'd1, 64'd0, 8'd2, 64'd0, 0, 32'd4);
    chk("R9", "wrap past top", next_pc, 64'd3);
    drive(8'h57, 64'hFFFF_FFFF_FFFF_FFFD, 8'd1, 64'd0, 8'd2, 64'd0, 16'h0001, 0);
    chk("R9", "fall through wraps", next_pc, 64'd2);
    drive(8'h77, 64'd2, 8'd1, 64'd0, 8'd2, 64'd0, 16'hFFF0, 0);
    chk("R9", "wrap below zero", next_pc, 64'hFFFF_FFFF_FFFF_FFF3);
  endtask

  initial begin
    op = 0; pc = 0; a_sel = 0; a_val = 0; b_sel = 0; b_val = 0; off16 = 0; off32 = 0;
    @(negedge clk);
    t_idle;
    t_cmpu;
    t_cmps;
    t_zero_reg;
    t_cond;
    t_jmp32;
    t_jmp16;
    t_wrap;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule